// File: doc/BRIEF.md
# Microcoded Register Bank with Instruction-Field Select

This block holds the working registers of a small accumulator machine. It has six general 8-bit registers, an accumulator, a scratch register that only microcode can reach, and a memory buffer register. All of them share one internal 8-bit bus. The low six bits of the instruction register name the registers. The lower 3-bit field names the register that drives the bus, and the upper 3-bit field names the register that captures it. Each field takes effect only while its own microword enable is high. One field value names no register at all.

Because the source drives the bus combinationally and the destination captures at the clock edge, a register-to-register move completes in one micro cycle. The scratch register and the memory buffer have their own load and drive enables and cannot be named by instruction fields. The memory buffer can also drive the external data pins. A plain source input lets an outside unit, such as an ALU result path, place a byte on the bus. The interface is all control and data pins with no handshake: the microsequencer owns every cycle, so the block never applies back-pressure.

Top module: `regbank_core`

## Requirements
- R1: An active-low asynchronous reset clears all seven registers, the scratch register and the memory buffer to 0x00.
- R2: With the read enable high, field bits 2:0 choose the bus source, using the codes 000 B, 001 C, 010 D, 011 E, 100 H, 101 L and 111 A.
- R3: Read code 110 drives nothing: the bus then shows the next lower-priority source, or 0x00 if no source is enabled.
- R4: With the write enable high, field bits 5:3 (same codes) load the bus value into the chosen register at the clock edge. Write code 110 changes no register.
- R5: When the read and write enables are high in the same cycle, the destination holds the source's value after that one edge and the source is unchanged, including when source and destination are the same register.
- R6: The scratch register loads from the bus when its load pin is high and drives the bus when its drive pin is high. No field code reads or writes it.
- R7: The memory buffer loads from the external data input, or from the bus when only the bus-load pin is high; the external load wins if both are high. The buffer drives the internal bus through its own enable. While its external enable is high, ext_data_o shows the buffer and ext_data_oe_o is 1; otherwise ext_data_o is 0x00 and ext_data_oe_o is 0.
- R8: Bus priority, highest first: memory buffer, scratch register, field-selected register, plain source input. With nothing enabled the bus reads 0x00.
- R9: With the write enable low, no register changes, whatever the field bits hold. With the read enable low, no register drives the bus.
- R10: acc_o always equals the accumulator (code 111).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Micro-cycle clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ir_i | input | 6 | Low six bits of the instruction register (5:3 destination, 2:0 source) |
| rd_dec_en_i | input | 1 | Read field enable |
| wr_dec_en_i | input | 1 | Write field enable |
| tmp_ld_i | input | 1 | Load scratch register from bus |
| tmp_oe_i | input | 1 | Scratch register drives bus |
| mbr_ld_ext_i | input | 1 | Load memory buffer from external data |
| mbr_ld_bus_i | input | 1 | Load memory buffer from bus |
| mbr_int_oe_i | input | 1 | Memory buffer drives internal bus |
| mbr_ext_oe_i | input | 1 | Memory buffer drives external data pins |
| ext_data_i | input | 8 | External data input |
| ext_data_o | output | 8 | External data output |
| ext_data_oe_o | output | 1 | External data output enable |
| src_en_i | input | 1 | Plain source drives bus |
| src_data_i | input | 8 | Plain source byte |
| bus_o | output | 8 | Internal bus value |
| acc_o | output | 8 | Accumulator contents |

## Verification
A bus transfer and a register load happen in the same cycle, so the central case is a move whose source read and destination write share one edge. The bench provokes every ordered pair of the eight codes, reserved code and self-moves included, after first reloading the destination with a distinct byte. It judges each pair by reading both codes back in the following cycles against an arithmetic model. A second collision is several bus sources enabled at once. Every one of the sixteen combinations of the four source enables is applied with distinct source bytes, and the bus must match the priority order.

// File: rtl/regbank_pkg.sv
package regbank_pkg;
  localparam int CODE_W    = 3;
  localparam int NUM_SLOTS = 1 << CODE_W;

  typedef enum logic [CODE_W-1:0] {
    SLOT_B    = 3'd0,
    SLOT_C    = 3'd1,
    SLOT_D    = 3'd2,
    SLOT_E    = 3'd3,
    SLOT_H    = 3'd4,
    SLOT_L    = 3'd5,
    SLOT_NONE = 3'd6,
    SLOT_ACC  = 3'd7
  } slot_code_e;
endpackage

// File: rtl/regbank_rd_decoder.sv
module regbank_rd_decoder #(
  parameter int CODE_W = 3,
  parameter int SKIP   = 6,
  localparam int N     = 1 << CODE_W
) (
  input  logic              en_i,
  input  logic [CODE_W-1:0] code_i,
  output logic [N-1:0]      sel_o
);
  for (genvar i = 0; i < N; i++) begin : g_sel
    if (i == SKIP) begin : g_res
      assign sel_o[i] = 1'b0;
    end else begin : g_hit
      assign sel_o[i] = en_i && (code_i == CODE_W'(i));
    end
  end
endmodule

// File: rtl/regbank_storage.sv
module regbank_storage #(
  parameter int DATA_W = 8,
  parameter int CODE_W = 3,
  parameter int SKIP   = 6,
  localparam int N     = 1 << CODE_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en_i,
  input  logic [CODE_W-1:0]          wr_code_i,
  input  logic [DATA_W-1:0]          wr_data_i,
  output logic [N-1:0][DATA_W-1:0]   q_o
);
  for (genvar i = 0; i < N; i++) begin : g_slot
    if (i == SKIP) begin : g_res
      assign q_o[i] = '0;
    end else begin : g_reg
      logic              hit;
      logic [DATA_W-1:0] val_q;
      assign hit = wr_en_i && (wr_code_i == CODE_W'(i));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   val_q <= '0;
        else if (hit) val_q <= wr_data_i;
      end
      assign q_o[i] = val_q;
    end
  end
endmodule

// File: rtl/regbank_bus_mux.sv
module regbank_bus_mux #(
  parameter int DATA_W = 8,
  parameter int N      = 8
) (
  input  logic                     mbr_oe_i,
  input  logic [DATA_W-1:0]        mbr_i,
  input  logic                     tmp_oe_i,
  input  logic [DATA_W-1:0]        tmp_i,
  input  logic [N-1:0]             rd_sel_i,
  input  logic [N-1:0][DATA_W-1:0] regs_i,
  input  logic                     src_oe_i,
  input  logic [DATA_W-1:0]        src_i,
  output logic [DATA_W-1:0]        bus_o
);
  logic [DATA_W-1:0] reg_val;
  logic              reg_hit;

  always_comb begin
    reg_val = '0;
    for (int i = 0; i < N; i++) begin
      if (rd_sel_i[i]) reg_val = reg_val | regs_i[i];
    end
    reg_hit = |rd_sel_i;
  end

  always_comb begin
    if (mbr_oe_i)      bus_o = mbr_i;
    else if (tmp_oe_i) bus_o = tmp_i;
    else if (reg_hit)  bus_o = reg_val;
    else if (src_oe_i) bus_o = src_i;
    else               bus_o = '0;
  end
endmodule

// File: rtl/regbank_core.sv
module regbank_core
  import regbank_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [2*CODE_W-1:0]   ir_i,
  input  logic                  rd_dec_en_i,
  input  logic                  wr_dec_en_i,
  input  logic                  tmp_ld_i,
  input  logic                  tmp_oe_i,
  input  logic                  mbr_ld_ext_i,
  input  logic                  mbr_ld_bus_i,
  input  logic                  mbr_int_oe_i,
  input  logic                  mbr_ext_oe_i,
  input  logic [DATA_W-1:0]     ext_data_i,
  output logic [DATA_W-1:0]     ext_data_o,
  output logic                  ext_data_oe_o,
  input  logic                  src_en_i,
  input  logic [DATA_W-1:0]     src_data_i,
  output logic [DATA_W-1:0]     bus_o,
  output logic [DATA_W-1:0]     acc_o
);
  localparam int SKIP = int'(SLOT_NONE);

  logic [CODE_W-1:0]                rd_code, wr_code;
  logic [NUM_SLOTS-1:0]             rd_sel;
  logic [NUM_SLOTS-1:0][DATA_W-1:0] regs;
  logic [DATA_W-1:0]                tmp_q, mbr_q, bus;

  assign rd_code = ir_i[CODE_W-1:0];
  assign wr_code = ir_i[2*CODE_W-1:CODE_W];

  regbank_rd_decoder #(.CODE_W(CODE_W), .SKIP(SKIP)) u_rd_dec (
    .en_i   (rd_dec_en_i),
    .code_i (rd_code),
    .sel_o  (rd_sel)
  );

  regbank_storage #(.DATA_W(DATA_W), .CODE_W(CODE_W), .SKIP(SKIP)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (wr_dec_en_i),
    .wr_code_i (wr_code),
    .wr_data_i (bus),
    .q_o       (regs)
  );

  regbank_bus_mux #(.DATA_W(DATA_W), .N(NUM_SLOTS)) u_mux (
    .mbr_oe_i (mbr_int_oe_i),
    .mbr_i    (mbr_q),
    .tmp_oe_i (tmp_oe_i),
    .tmp_i    (tmp_q),
    .rd_sel_i (rd_sel),
    .regs_i   (regs),
    .src_oe_i (src_en_i),
    .src_i    (src_data_i),
    .bus_o    (bus)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        tmp_q <= '0;
    else if (tmp_ld_i) tmp_q <= bus;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            mbr_q <= '0;
    else if (mbr_ld_ext_i) mbr_q <= ext_data_i;
    else if (mbr_ld_bus_i) mbr_q <= bus;
  end

  assign ext_data_o    = mbr_ext_oe_i ? mbr_q : '0;
  assign ext_data_oe_o = mbr_ext_oe_i;
  assign bus_o         = bus;
  assign acc_o         = regs[int'(SLOT_ACC)];
endmodule

// File: rtl/regbank_core_chk.sv
module regbank_core_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [5:0]        ir_i,
  input logic              rd_dec_en_i,
  input logic              wr_dec_en_i,
  input logic              tmp_ld_i,
  input logic              tmp_oe_i,
  input logic              mbr_ld_ext_i,
  input logic              mbr_int_oe_i,
  input logic              mbr_ext_oe_i,
  input logic [DATA_W-1:0] ext_data_i,
  input logic [DATA_W-1:0] ext_data_o,
  input logic              src_en_i,
  input logic [DATA_W-1:0] bus_o,
  input logic [DATA_W-1:0] acc_o
);
  assert_acc_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> acc_o == '0);

  assert_reserved_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_dec_en_i && ir_i[2:0] == 3'b110 && !mbr_int_oe_i && !tmp_oe_i && !src_en_i)
      |-> bus_o == '0);

  assert_acc_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_dec_en_i && ir_i[5:3] == 3'b111) |=> acc_o == $past(bus_o));

  assert_acc_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_dec_en_i && ir_i[5:3] == 3'b111) |=> $stable(acc_o));

  assert_scratch_roundtrip_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tmp_ld_i ##1 (tmp_oe_i && !mbr_int_oe_i) |-> bus_o == $past(bus_o));

  assert_buffer_ext_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mbr_ld_ext_i ##1 mbr_ext_oe_i |-> ext_data_o == $past(ext_data_i));

  assert_buffer_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mbr_int_oe_i && mbr_ext_oe_i) |-> bus_o == ext_data_o);
endmodule

bind regbank_core regbank_core_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_regbank_core.sv
`timescale 1ns/1ps
module tb_regbank_core;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] ir;
  logic       rd_en, wr_en, tld, toe, mlde, mldb, mint, mext, sen;
  logic [7:0] ext_in, src;
  logic [7:0] ext_out, bus, acc;
  logic       ext_oe;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 0;

  logic [7:0] m_reg [8];
  logic [7:0] m_t, m_mbr;

  always #2 clk = ~clk;

  regbank_core dut (
    .clk(clk), .rst_n(rst_n), .ir_i(ir),
    .rd_dec_en_i(rd_en), .wr_dec_en_i(wr_en),
    .tmp_ld_i(tld), .tmp_oe_i(toe),
    .mbr_ld_ext_i(mlde), .mbr_ld_bus_i(mldb),
    .mbr_int_oe_i(mint), .mbr_ext_oe_i(mext),
    .ext_data_i(ext_in), .ext_data_o(ext_out), .ext_data_oe_o(ext_oe),
    .src_en_i(sen), .src_data_i(src),
    .bus_o(bus), .acc_o(acc)
  );

  task automatic idle();
    ir = 6'd0; rd_en = 0; wr_en = 0; tld = 0; toe = 0;
    mlde = 0; mldb = 0; mint = 0; mext = 0; sen = 0;
    ext_in = 8'h00; src = 8'h00;
  endtask

  task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // Drive is already set; check outputs mid-cycle, then update the model at the edge.
  task automatic apply(input string tag);
    logic [7:0] eb;
    @(negedge clk);
    #1;
    if (mint)                                   eb = m_mbr;
    else if (toe)                               eb = m_t;
    else if (rd_en && ir[2:0] != 3'd6)          eb = m_reg[ir[2:0]];
    else if (sen)                               eb = src;
    else                                        eb = 8'h00;
    check8(tag, bus, eb);
    check8("R10 acc", acc, m_reg[7]);
    check8("R7 ext data", ext_out, mext ? m_mbr : 8'h00);
    check8("R7 ext oe", {7'd0, ext_oe}, {7'd0, mext});
    @(posedge clk);
    #1;
    if (wr_en && ir[5:3] != 3'd6) m_reg[ir[5:3]] = eb;
    if (tld) m_t = eb;
    if (mlde) m_mbr = ext_in;
    else if (mldb) m_mbr = eb;
  endtask

  task automatic rd_code(input int c, input string tag);
    idle(); ir = {3'd6, 3'(c)}; rd_en = 1; apply(tag);
  endtask

  task automatic wr_src(input int c, input logic [7:0] v, input string tag);
    idle(); ir = {3'(c), 3'd0}; wr_en = 1; sen = 1; src = v; apply(tag);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) m_reg[i] = 8'h00;
    m_t = 8'h00; m_mbr = 8'h00;
    idle();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 / R2 / R3: everything reads zero after reset
    for (int c = 0; c < 8; c++) rd_code(c, "R1 reset read");
    idle(); toe = 1; apply("R1 scratch reset");
    idle(); mint = 1; apply("R1 buffer reset");

    // R4: load every code from the plain source; code 6 must change nothing
    for (int c = 0; c < 8; c++) wr_src(c, 8'(8'h13 * c + 8'h21), "R4 write");
    for (int c = 0; c < 8; c++) rd_code(c, "R2 read back");

    // R3: reserved read falls through to the plain source
    idle(); ir = 6'o06; rd_en = 1; sen = 1; src = 8'h9C; apply("R3 reserved fallthrough");

    // R5: every ordered pair, destination reloaded first
    for (int s = 0; s < 8; s++) begin
      for (int d = 0; d < 8; d++) begin
        wr_src(d, {3'(s), 3'(d), 2'b10} ^ 8'h5A, "R4 reload");
        idle(); ir = {3'(d), 3'(s)}; rd_en = 1; wr_en = 1; apply("R5 move");
        rd_code(d, "R5 dest");
        rd_code(s, "R5 source");
      end
    end

    // R9: write field set but write disabled; read disabled shows no register
    for (int c = 0; c < 8; c++) begin
      idle(); ir = {3'(c), 3'(c)}; sen = 1; src = 8'hE7; apply("R9 rd disabled");
    end
    for (int c = 0; c < 8; c++) rd_code(c, "R9 nothing written");

    // R6: scratch register load, drive, and move into a register
    idle(); sen = 1; src = 8'h3C; tld = 1; apply("R6 scratch load");
    idle(); toe = 1; apply("R6 scratch drive");
    idle(); toe = 1; wr_en = 1; ir = {3'd7, 3'd0}; apply("R6 scratch to acc");
    for (int c = 0; c < 8; c++) rd_code(c, "R6 no field reaches scratch");
    idle(); toe = 1; apply("R6 scratch kept");

    // R7: buffer loads, external priority, drives
    idle(); mlde = 1; ext_in = 8'hA5; apply("R7 buffer ext load");
    idle(); mext = 1; apply("R7 buffer out");
    idle(); mint = 1; wr_en = 1; ir = {3'd2, 3'd0}; apply("R7 buffer to D");
    rd_code(2, "R7 D holds buffer");
    idle(); rd_en = 1; ir = {3'd0, 3'd4}; mldb = 1; apply("R7 buffer bus load");
    idle(); mint = 1; mext = 1; apply("R7 buffer from bus");
    idle(); rd_en = 1; ir = {3'd0, 3'd1}; mldb = 1; mlde = 1; ext_in = 8'h5E; apply("R7 ext wins");
    idle(); mint = 1; mext = 1; apply("R7 ext won");

    // R8: all sixteen source-enable combinations
    idle(); mlde = 1; ext_in = 8'hA5; sen = 1; src = 8'h3C; tld = 1; apply("R8 setup");
    wr_src(0, 8'h81, "R8 setup B");
    for (int m = 0; m < 16; m++) begin
      idle(); ir = 6'o00; sen = m[0]; src = 8'h42; rd_en = m[1]; toe = m[2]; mint = m[3];
      apply("R8 priority");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule